// File: doc/BRIEF.md
# Parameter Memory Write Guard

This block fronts the parameter storage of one serial channel. The host can read the storage at any time. Host writes are checked against the enable state of the channel's transmitter and receiver. That state is tracked from a small set of host commands and from a strobe that marks the end of the frame being sent.

The storage is word-addressed, with per-byte write enables. The lower part of the index space holds receive parameters. The upper part holds transmit parameters.

Transmit parameters may be changed only once the transmitter has really stopped. An immediate stop command stops it at once. A graceful stop waits until the frame in flight has finished.

Receive parameters may be changed only while the receiver is off. There is one exception: the maximum-receive-length word may be replaced while the receiver runs, as long as the write is a single full-width access.

A refused write changes nothing and raises a one-cycle error pulse.

Top module: `param_write_guard`

## Requirements
- R1: After synchronous reset the transmitter is stopped, the receiver is off, every storage word reads 0 and `wr_err` is 0.
- R2: When `rd_en` is high, `rd_data` shows the word at `rd_idx` on the next cycle, whatever the channel state. If a write to that word happens in the same cycle, `rd_data` shows the value before the write. Without `rd_en`, `rd_data` holds its value.
- R3: A write whose index is at or above SPLIT is accepted only while the transmitter is stopped.
- R4: Command code 1 (immediate stop) stops the transmitter at once. Transmit writes are accepted from the next cycle on.
- R5: Command code 2 (graceful stop), given while the transmitter is active, leaves it pending. Transmit writes stay refused until a `frame_done` strobe is seen in the pending state, and they are accepted from the next cycle on. Code 1 also ends the pending state.
- R6: Command code 3 (restart) makes a stopped transmitter active, which closes the transmit write window from the next cycle. Code 3 is ignored when the transmitter is pending or active.
- R7: A write whose index is below SPLIT is accepted while the receiver is off. Code 4 turns the receiver on and code 5 turns it off, both taking effect for writes in the next cycle.
- R8: Command code 6 (close current receive buffer) leaves the receiver state unchanged, so it never opens the receive write window.
- R9: A write to index MRL_IDX with all byte enables set is accepted even while the receiver is on. Any partial write to that index while the receiver is on is refused.
- R10: A refused write leaves the storage unchanged and makes `wr_err` high for exactly the next cycle.
- R11: The region is chosen by index alone: index SPLIT-1 is a receive word and index SPLIT is a transmit word.
- R12: An accepted write changes only the bytes whose `wr_be` bit is set (bit b covers data bits 8b+7..8b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | 1 stop, 2 graceful stop, 3 restart, 4 receiver on, 5 receiver off, 6 close receive buffer |
| frame_done | input | 1 | Frame in flight has finished transmitting |
| wr_en | input | 1 | Host write request |
| wr_idx | input | IDX_W | Word index of write |
| wr_be | input | DATA_W/8 | Byte enables of write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Host read request |
| rd_idx | input | IDX_W | Word index of read |
| rd_data | output | DATA_W | Read data, one cycle after `rd_en` |
| wr_err | output | 1 | One-cycle pulse after a refused write |

## Verification
A wrong transmitter or receiver state does not show at once; it shows on the next write aimed at the affected region. That write is either refused, with `wr_err` pulsing one cycle later, or wrongly accepted, which shows on the next read of that word. The bench therefore mixes writes and reads densely around every command and every `frame_done` strobe. It checks `wr_err` and `rd_data` on every clock against a behavioural model, so a wrong state is caught within two cycles of the first access that depends on it.

// File: rtl/pmwg_pkg.sv
package pmwg_pkg;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_TX_STOP    = 3'd1,
        CMD_TX_GSTOP   = 3'd2,
        CMD_TX_RESTART = 3'd3,
        CMD_RX_ON      = 3'd4,
        CMD_RX_OFF     = 3'd5,
        CMD_RX_CLOSE   = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        TX_ACTIVE  = 2'd0,
        TX_GPEND   = 2'd1,
        TX_STOPPED = 2'd2
    } tx_state_e;

    typedef enum logic {
        REGION_RX = 1'b0,
        REGION_TX = 1'b1
    } region_e;

    typedef struct packed {
        logic commit;
        logic reject;
    } verdict_t;

    function automatic region_e region_of(input int unsigned idx, input int unsigned split);
        return (idx < split) ? REGION_RX : REGION_TX;
    endfunction

endpackage

// File: rtl/pmwg_tx_ctl.sv
module pmwg_tx_ctl
    import pmwg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  cmd_e      cmd,
    input  logic      frame_done,
    output tx_state_e state
);

    tx_state_e state_q, state_d;
    logic      stop_cmd, gstop_cmd, restart_cmd;

    assign stop_cmd    = cmd_valid && (cmd == CMD_TX_STOP);
    assign gstop_cmd   = cmd_valid && (cmd == CMD_TX_GSTOP);
    assign restart_cmd = cmd_valid && (cmd == CMD_TX_RESTART);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_ACTIVE: begin
                if (stop_cmd)       state_d = TX_STOPPED;
                else if (gstop_cmd) state_d = TX_GPEND;
            end
            TX_GPEND: begin
                if (stop_cmd || frame_done) state_d = TX_STOPPED;
            end
            TX_STOPPED: begin
                if (restart_cmd) state_d = TX_ACTIVE;
            end
            default: state_d = TX_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_STOPPED;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R4: immediate stop takes effect on the next edge
    a_r4_stop_now: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> (state_q == TX_STOPPED));

    // R6: restart never revives a pending transmitter
    a_r6_no_restart_pending: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_GPEND) |=> (state_q != TX_ACTIVE));

    // R5: pending holds until the frame ends or a hard stop arrives
    a_r5_pending_waits: assert property (@(posedge clk) disable iff (rst)
        ((state_q == TX_GPEND) && !frame_done && !stop_cmd) |=> (state_q == TX_GPEND));

endmodule

// File: rtl/pmwg_rx_ctl.sv
module pmwg_rx_ctl
    import pmwg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  cmd_e cmd,
    output logic rx_on
);

    logic rx_on_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_on_q <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd == CMD_RX_ON)       rx_on_q <= 1'b1;
            else if (cmd == CMD_RX_OFF) rx_on_q <= 1'b0;
        end
    end

    assign rx_on = rx_on_q;

    // R8: closing the current buffer leaves reception running
    a_r8_close_keeps_rx: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd == CMD_RX_CLOSE)) |=> $stable(rx_on_q));

endmodule

// File: rtl/pmwg_wr_gate.sv
module pmwg_wr_gate
    import pmwg_pkg::*;
#(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned BYTES   = 2,
    parameter int unsigned SPLIT   = 16,
    parameter int unsigned MRL_IDX = 3
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BYTES-1:0] wr_be,
    input  tx_state_e        tx_state,
    input  logic             rx_on,
    output verdict_t         verdict
);

    region_e region;
    logic    full_width;
    logic    mrl_hit;
    logic    allowed;

    assign region     = region_of(int'(wr_idx), SPLIT);
    assign full_width = &wr_be;
    assign mrl_hit    = (int'(wr_idx) == MRL_IDX);

    always_comb begin
        if (region == REGION_TX) allowed = (tx_state == TX_STOPPED);
        else                     allowed = !rx_on || (mrl_hit && full_width);
    end

    assign verdict.commit = wr_en && allowed;
    assign verdict.reject = wr_en && !allowed;

endmodule

// File: rtl/pmwg_store.sv
module pmwg_store #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] rd_q;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{wr_be[b]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit) begin
            mem_q[wr_idx] <= (mem_q[wr_idx] & ~lane_mask) | (wr_data & lane_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= mem_q[rd_idx];
    end

    assign rd_data = rd_q;

    // R12: a lane without its enable keeps its byte across a write
    for (genvar b = 0; b < BYTES; b++) begin : g_hold
        a_r12_lane_hold: assert property (@(posedge clk) disable iff (rst)
            (commit && !wr_be[b]) |=> (mem_q[$past(wr_idx)][b*8 +: 8] == $past(mem_q[wr_idx][b*8 +: 8])));
    end

endmodule

// File: rtl/param_write_guard.sv
module param_write_guard
    import pmwg_pkg::*;
#(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SPLIT   = 16,
    parameter int unsigned MRL_IDX = 3,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned BYTES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              frame_done,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_err
);

    cmd_e      cmd;
    tx_state_e tx_state;
    logic      rx_on;
    verdict_t  verdict;
    logic      err_q;

    assign cmd = cmd_e'(cmd_code);

    pmwg_tx_ctl u_tx (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .frame_done (frame_done),
        .state      (tx_state)
    );

    pmwg_rx_ctl u_rx (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .rx_on     (rx_on)
    );

    pmwg_wr_gate #(
        .IDX_W   (IDX_W),
        .BYTES   (BYTES),
        .SPLIT   (SPLIT),
        .MRL_IDX (MRL_IDX)
    ) u_gate (
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_be    (wr_be),
        .tx_state (tx_state),
        .rx_on    (rx_on),
        .verdict  (verdict)
    );

    pmwg_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .commit  (verdict.commit),
        .wr_idx  (wr_idx),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= verdict.reject;
    end

    assign wr_err = err_q;

    // R3: transmit words are locked unless the state machine reports stopped
    a_r3_tx_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_idx) >= SPLIT) && (tx_state != TX_STOPPED)) |-> !verdict.commit);

    // R9: a full-width length update is never refused
    a_r9_mrl_full_ok: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_idx) == MRL_IDX) && (&wr_be)) |=> !wr_err);

    // R10: the error pulse only follows a write request
    a_r10_err_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en));

    // R10: a request with no write behind it never raises an error
    a_r10_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_err);

endmodule

// File: tb/test_param_write_guard.sv
module test_param_write_guard;

    localparam int DEPTH = 32;
    localparam int DW    = 16;
    localparam int SPLIT = 16;
    localparam int MRL   = 3;
    localparam int IW    = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [2:0]    cmd_code;
    logic          frame_done;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [1:0]    wr_be;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [IW-1:0] rd_idx;
    logic [DW-1:0] rd_data;
    logic          wr_err;

    always #5 clk = ~clk;

    param_write_guard i_param_write_guard (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .frame_done(frame_done), .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be),
        .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_err(wr_err)
    );

    // behavioural reference: 0 running, 1 waiting for frame end, 2 halted
    logic [DW-1:0] ref_mem [DEPTH];
    int            ref_tx;
    bit            ref_rx;
    logic [DW-1:0] exp_rd;
    bit            exp_err;
    bit            armed;
    string         cur_req;
    int            n_cmp;
    int            n_bad;
    bit            finished;

    task automatic compare_now();
        n_cmp++;
        if (wr_err !== exp_err) begin
            n_bad++;
            $display("FAIL %s wr_err actual=%0b expected=%0b at %0t", cur_req, wr_err, exp_err, $time);
        end
        n_cmp++;
        if (rd_data !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rd_data actual=%h expected=%h at %0t", cur_req, rd_data, exp_rd, $time);
        end
    endtask

    // one clock: check the last edge's outcome, then drive and predict the next
    task automatic cyc(input int c, input int fd, input int w, input int widx,
                       input int be, input int wd, input int r, input int ridx);
        bit ok;
        int prev;
        logic [DW-1:0] m;
        @(negedge clk);
        if (armed) compare_now();
        cmd_valid  = (c != 0);
        cmd_code   = 3'(c);
        frame_done = (fd != 0);
        wr_en      = (w != 0);
        wr_idx     = IW'(widx);
        wr_be      = 2'(be);
        wr_data    = DW'(wd);
        rd_en      = (r != 0);
        rd_idx     = IW'(ridx);
        if (widx >= SPLIT) ok = (ref_tx == 2);
        else               ok = !ref_rx || (widx == MRL && be == 3);
        exp_err = (w != 0) && !ok;
        if (r != 0) exp_rd = ref_mem[ridx];
        if (w != 0 && ok) begin
            m = ref_mem[widx];
            if (be & 1) m[7:0]  = wd[7:0];
            if (be & 2) m[15:8] = wd[15:8];
            ref_mem[widx] = m;
        end
        prev = ref_tx;
        if (c == 1) ref_tx = 2;
        else if (c == 2 && ref_tx == 0) ref_tx = 1;
        else if (c == 3 && ref_tx == 2) ref_tx = 0;
        else if (c == 4) ref_rx = 1;
        else if (c == 5) ref_rx = 0;
        if (prev == 1 && fd != 0) ref_tx = 2;
        armed = 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        n_cmp = 0; n_bad = 0; armed = 0; finished = 0;
        cur_req = "R1";
        rst = 1'b1;
        cmd_valid = 0; cmd_code = 0; frame_done = 0; wr_en = 0; wr_idx = 0;
        wr_be = 0; wr_data = 0; rd_en = 0; rd_idx = 0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        ref_tx = 2; ref_rx = 0; exp_rd = '0; exp_err = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        compare_now();
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 0, 0, 0, 1, i);

        // R11, R7, R3: initial writes while both halves are disabled
        cur_req = "R11";
        cyc(0, 0, 1, 15, 3, 'h1111, 0, 0);
        cyc(0, 0, 1, 16, 3, 'h2222, 1, 15);
        cyc(0, 0, 1, 20, 3, 'hA5A5, 1, 16);
        cur_req = "R7";
        cyc(0, 0, 1, MRL, 3, 'h0100, 1, 20);
        cyc(0, 0, 1, 5, 3, 'h0505, 1, MRL);

        // enable both sides
        cur_req = "R6";
        cyc(3, 0, 0, 0, 0, 0, 1, 5);
        cyc(4, 0, 0, 0, 0, 0, 0, 0);
        cur_req = "R3";
        cyc(0, 0, 1, 20, 3, 'hDEAD, 0, 0);
        cyc(0, 0, 1, 31, 1, 'hBEEF, 1, 20);
        cur_req = "R7";
        cyc(0, 0, 1, 5, 3, 'h7777, 1, 31);
        cyc(0, 0, 0, 0, 0, 0, 1, 5);
        // R11: boundary with receiver on, transmitter active
        cur_req = "R11";
        cyc(0, 0, 1, 15, 3, 'h3333, 0, 0);
        cyc(0, 0, 1, 16, 3, 'h4444, 1, 15);
        cyc(0, 0, 0, 0, 0, 0, 1, 16);
        // R9: length word exception
        cur_req = "R9";
        cyc(0, 0, 1, MRL, 3, 'h0200, 0, 0);
        cyc(0, 0, 1, MRL, 1, 'h00FF, 1, MRL);
        cyc(0, 0, 1, MRL, 2, 'hFF00, 1, MRL);
        cyc(0, 0, 0, 0, 0, 0, 1, MRL);
        // R2: read during active channel, with a same-cycle write
        cur_req = "R2";
        cyc(0, 0, 1, MRL, 3, 'h0400, 1, MRL);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, MRL);

        // R4: immediate stop
        cur_req = "R4";
        cyc(1, 0, 1, 25, 3, 'h1234, 0, 0);
        cyc(0, 0, 1, 25, 3, 'h5678, 1, 25);
        cyc(0, 0, 0, 0, 0, 0, 1, 25);
        // R12: partial lanes on an open word
        cur_req = "R12";
        cyc(0, 0, 1, 25, 2, 'hAB00, 0, 0);
        cyc(0, 0, 1, 25, 1, 'h00CD, 1, 25);
        cyc(0, 0, 1, 25, 0, 'hFFFF, 1, 25);
        cyc(0, 0, 0, 0, 0, 0, 1, 25);

        // R6: restart closes the window
        cur_req = "R6";
        cyc(3, 0, 1, 25, 3, 'h0001, 0, 0);
        cyc(0, 0, 1, 25, 3, 'h0002, 1, 25);
        cyc(0, 0, 0, 0, 0, 0, 1, 25);

        // R5: graceful stop waits for the frame
        cur_req = "R5";
        cyc(2, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 26, 3, 'h0AAA, 0, 0);
        idle(3);
        cyc(0, 0, 1, 26, 3, 'h0BBB, 1, 26);
        cur_req = "R6";
        cyc(3, 0, 1, 26, 3, 'h0CCC, 0, 0);
        cur_req = "R5";
        cyc(0, 1, 1, 26, 3, 'h0DDD, 0, 0);
        cyc(0, 0, 1, 26, 3, 'h0EEE, 1, 26);
        cyc(0, 0, 0, 0, 0, 0, 1, 26);
        // R5: hard stop ends the pending state
        cyc(3, 0, 0, 0, 0, 0, 0, 0);
        cyc(2, 0, 1, 27, 3, 'h1010, 0, 0);
        cyc(1, 0, 1, 27, 3, 'h2020, 0, 0);
        cyc(0, 0, 1, 27, 3, 'h3030, 1, 27);
        cyc(0, 0, 0, 0, 0, 0, 1, 27);
        // R5: frame end while active does not count
        cyc(3, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 28, 3, 'h4040, 0, 0);
        cyc(2, 1, 1, 28, 3, 'h5050, 0, 0);
        cyc(0, 0, 1, 28, 3, 'h6060, 1, 28);

        // R8: close leaves the receiver on
        cur_req = "R8";
        cyc(6, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 7, 3, 'h7070, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 7);
        // R7: receiver off opens the window, on closes it
        cur_req = "R7";
        cyc(5, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 7, 3, 'h8080, 0, 0);
        cyc(4, 0, 0, 0, 0, 0, 1, 7);
        cyc(0, 0, 1, 7, 3, 'h9090, 0, 0);
        cur_req = "R10";
        cyc(0, 0, 1, 8, 3, 'h1111, 1, 7);
        cyc(0, 0, 0, 0, 0, 0, 1, 8);
        idle(2);

        // mixed traffic covering R2, R3, R7, R10 together
        cur_req = "R2+R3+R7+R10 mixed";
        for (int k = 0; k < 4000; k++) begin
            int c;
            c = (($urandom % 5) == 0) ? int'($urandom % 7) : 0;
            cyc(c, (($urandom % 6) == 0) ? 1 : 0, int'($urandom % 2),
                int'($urandom % DEPTH), int'($urandom % 4), int'($urandom % 65536),
                int'($urandom % 2), int'($urandom % DEPTH));
        end
        idle(2);
        finish_run();
    end

endmodule